// File: doc/BRIEF.md
# Time-Coded Synapse Multiplier

This block forms the signed product of a 5-bit input and a 5-bit weight without an array multiplier. Each operand is a sign bit plus a 4-bit magnitude n, which stands for the fraction n/15. A frame-start strobe captures both operands and opens a frame of 15 time slots, one slot per clock. The input magnitude becomes a pulse that is high for the first x slots of the frame. The weight magnitude becomes a pattern of high slots spread across the frame. One AND gate combines the two streams, and a small counter counts the slots where both are high.

When the frame ends, the count is the rounded product magnitude. The sign is the exclusive-OR of the two operand signs. The result stays in a register and is marked by a one-cycle valid pulse. Several of these units can be placed side by side as the synapses of a neural cell. Summing their products is done outside this block.

Top module: `tcode_synapse_mul`

## Requirements
- R1: While reset (rstN low) is applied, prodMag is 0, prodSign is 0 and prodValid is 0.
- R2: On the clock edge that samples frameStart high, prodMag is cleared to 0 and prodSign to 0, and prodValid is 0 in the following cycle.
- R3: prodValid is high for exactly one cycle. It rises on the 15th rising edge after the edge that sampled frameStart, provided no further frameStart was sampled in between.
- R4: The product magnitude is floor((2·x·w + 15) / 30), where x is inMag and w is wtMag. For example, 8 and 9 give 5, 15 and 15 give 15, 1 and 7 give 0, and 1 and 8 give 1.
- R5: prodSign is inSign XOR wtSign (1 means negative) whenever the magnitude is nonzero. A zero product always has prodSign equal to 0.
- R6: A magnitude of 0 on either operand gives a product magnitude of 0 with a positive sign, whatever the other operand and the signs are.
- R7: The operands are sampled only on the frameStart edge. Changes to inMag, inSign, wtMag or wtSign during a frame have no effect on that frame's result.
- R8: A frameStart sampled during a running frame abandons that frame and starts a new one. The abandoned frame produces no valid pulse, and the result follows the new operands with the timing of R3.
- R9: After the valid pulse, prodMag and prodSign hold their value until the next frameStart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one time slot per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Captures the operands and starts a 15-slot frame |
| inMag | input | 4 | Input magnitude, 0..15 (value n/15) |
| inSign | input | 1 | Input sign, 1 = negative |
| wtMag | input | 4 | Weight magnitude, 0..15 (value n/15) |
| wtSign | input | 1 | Weight sign, 1 = negative |
| prodMag | output | 4 | Product magnitude, 0..15 |
| prodSign | output | 1 | Product sign, 1 = negative |
| prodValid | output | 1 | One-cycle pulse when the product is ready |

## Verification
The bench sweeps every pair of magnitudes. This covers the rounding midpoints, such as 8 with 9 and the boundary between 1 with 7 and 1 with 8. A weight pattern that was misplaced or off by one slot would show up there as a count one too high or too low. Products that round to zero are paired with opposite signs, which exposes a design that reports a negative zero. The bench also changes the operands in the middle of a frame and restarts a frame in the middle. A design that reads its ports live, or lets an abandoned frame finish, would give a wrong result or a valid pulse at the wrong cycle.

// File: rtl/tcsm_pkg.sv
package tcsm_pkg;

  // strobes sent from the slot sequencer to the datapath
  typedef struct packed {
    logic load;  // capture operands, clear result
    logic step;  // process one slot
    logic last;  // the slot being processed is the final one
  } slotStrobe_t;

endpackage

// File: rtl/tcsm_ctrl.sv
module tcsm_ctrl
  import tcsm_pkg::*;
#(
  parameter int SLOTS  = 15,
  parameter int SLOT_W = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  output slotStrobe_t strb
);

  logic              busy;
  logic [SLOT_W-1:0] slotIdx;
  logic              atLast;

  assign atLast = (slotIdx == SLOT_W'(SLOTS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      slotIdx <= '0;
    end else if (frameStart) begin
      busy    <= 1'b1;
      slotIdx <= '0;
    end else if (busy) begin
      if (atLast) begin
        busy    <= 1'b0;
        slotIdx <= '0;
      end else begin
        slotIdx <= slotIdx + 1'b1;
      end
    end
  end

  always_comb begin
    strb.load = frameStart;
    strb.step = busy && !frameStart;
    strb.last = busy && !frameStart && atLast;
  end

endmodule

// File: rtl/tcsm_datapath.sv
module tcsm_datapath
  import tcsm_pkg::*;
#(
  parameter int MAG_W = 4,
  parameter int SLOTS = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  slotStrobe_t      strb,
  input  logic [MAG_W-1:0] inMag,
  input  logic             inSign,
  input  logic [MAG_W-1:0] wtMag,
  input  logic             wtSign,
  output logic [MAG_W-1:0] prodMag,
  output logic             prodSign,
  output logic             prodValid
);

  localparam int ACC_W = 2 * MAG_W + 2;

  // spread weight pattern, computed from the weight port at load time
  logic [SLOTS-1:0] wtPattern;
  logic [ACC_W-1:0] wtWide;
  assign wtWide = {{(ACC_W - MAG_W){1'b0}}, wtMag};

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot
    logic [ACC_W-1:0] loNum, hiNum;
    assign loNum = ACC_W'(2 * k) * wtWide + ACC_W'(SLOTS);
    assign hiNum = ACC_W'(2 * (k + 1)) * wtWide + ACC_W'(SLOTS);
    assign wtPattern[k] = (hiNum / ACC_W'(2 * SLOTS)) != (loNum / ACC_W'(2 * SLOTS));
  end

  logic [SLOTS-1:0] wtShift;     // bit 0 is the current slot's weight bit
  logic [MAG_W-1:0] inLeft;      // input slots still to be emitted
  logic             signXor;
  logic [MAG_W-1:0] coinc;
  logic             inStream, wtStream, hit;
  logic [MAG_W-1:0] coincNext;

  assign inStream  = (inLeft != '0);
  assign wtStream  = wtShift[0];
  assign hit       = inStream & wtStream;
  assign coincNext = coinc + MAG_W'(hit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wtShift   <= '0;
      inLeft    <= '0;
      signXor   <= 1'b0;
      coinc     <= '0;
      prodMag   <= '0;
      prodSign  <= 1'b0;
      prodValid <= 1'b0;
    end else begin
      prodValid <= 1'b0;
      if (strb.load) begin
        wtShift  <= wtPattern;
        inLeft   <= inMag;
        signXor  <= inSign ^ wtSign;
        coinc    <= '0;
        prodMag  <= '0;
        prodSign <= 1'b0;
      end else if (strb.step) begin
        wtShift <= wtShift >> 1;
        if (inStream) inLeft <= inLeft - 1'b1;
        coinc <= coincNext;
        if (strb.last) begin
          prodMag   <= coincNext;
          prodSign  <= signXor && (coincNext != '0);
          prodValid <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/tcode_synapse_mul.sv
module tcode_synapse_mul
  import tcsm_pkg::*;
#(
  parameter int MAG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic [MAG_W-1:0] inMag,
  input  logic             inSign,
  input  logic [MAG_W-1:0] wtMag,
  input  logic             wtSign,
  output logic [MAG_W-1:0] prodMag,
  output logic             prodSign,
  output logic             prodValid
);

  localparam int SLOTS  = (1 << MAG_W) - 1;
  localparam int SLOT_W = $clog2(SLOTS);

  slotStrobe_t strb;

  tcsm_ctrl #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .strb(strb)
  );

  tcsm_datapath #(.MAG_W(MAG_W), .SLOTS(SLOTS)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .inMag(inMag), .inSign(inSign), .wtMag(wtMag), .wtSign(wtSign),
    .prodMag(prodMag), .prodSign(prodSign), .prodValid(prodValid)
  );

endmodule

// File: rtl/tcsm_checker.sv
module tcsm_checker #(
  parameter int MAG_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameStart,
  input logic [MAG_W-1:0] prodMag,
  input logic             prodSign,
  input logic             prodValid
);

  localparam int SLOTS = (1 << MAG_W) - 1;
  localparam int CNT_W = MAG_W + 2;

  // edges since the last sampled frameStart, saturating; 0 = no frame yet
  logic [CNT_W-1:0] sinceStart;
  always_ff @(posedge clk) begin
    if (!rstN) sinceStart <= '0;
    else if (frameStart) sinceStart <= CNT_W'(1);
    else if (sinceStart != '0 && sinceStart < CNT_W'(SLOTS + 2)) sinceStart <= sinceStart + 1'b1;
  end

  // R2
  clear_on_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (prodMag == '0 && !prodSign && !prodValid));

  // R3
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    prodValid |=> !prodValid);

  // R3
  valid_timing_chk: assert property (@(posedge clk) disable iff (!rstN)
    prodValid |-> (sinceStart == CNT_W'(SLOTS + 1)));

  // R5
  zero_positive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (prodMag == '0) |-> !prodSign);

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(frameStart) && !prodValid) |-> ($stable(prodMag) && $stable(prodSign)));

endmodule

bind tcode_synapse_mul tcsm_checker #(.MAG_W(MAG_W)) chk_i (
  .clk(clk), .rstN(rstN), .frameStart(frameStart),
  .prodMag(prodMag), .prodSign(prodSign), .prodValid(prodValid)
);

// File: tb/tcode_synapse_mul_tb.sv
`timescale 1ns/1ps
module tcode_synapse_mul_tb_top;

  localparam int L = 15;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStart = 1'b0;
  logic [3:0] inMag = '0, wtMag = '0;
  logic       inSign = 1'b0, wtSign = 1'b0;
  logic [3:0] prodMag;
  logic       prodSign, prodValid;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tcode_synapse_mul dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart),
    .inMag(inMag), .inSign(inSign), .wtMag(wtMag), .wtSign(wtSign),
    .prodMag(prodMag), .prodSign(prodSign), .prodValid(prodValid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lvl(input int n, input int w);
    return (2 * n * w + L) / (2 * L);
  endfunction

  // behavioural reference, advanced on every rising edge
  bit mBusy = 0;
  int mSlot = 0, mX = 0, mW = 0, mCnt = 0, mMag = 0;
  bit mS = 0, mSign = 0, mValid = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mSlot = 0; mCnt = 0; mMag = 0; mSign = 0; mValid = 0;
    end else begin
      mValid = 0;
      if (frameStart) begin
        mBusy = 1; mSlot = 0; mX = inMag; mW = wtMag; mS = inSign ^ wtSign;
        mCnt = 0; mMag = 0; mSign = 0;
      end else if (mBusy) begin
        if (mSlot < mX && lvl(mSlot + 1, mW) > lvl(mSlot, mW)) mCnt++;
        if (mSlot == L - 1) begin
          mBusy = 0; mMag = mCnt; mSign = mS && (mCnt != 0); mValid = 1;
        end else mSlot++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R4 model magnitude", prodMag, mMag);
      chk("R5 model sign", prodSign, mSign);
      chk("R3 model valid", prodValid, mValid);
    end
  end

  // drive a frame at the current negedge, then check the outcome
  task automatic runFrame(input int x, input bit xs, input int w, input bit ws, input bit scramble);
    int expMag;
    bit expSign;
    expMag = lvl(x, w);
    expSign = (xs ^ ws) && (expMag != 0);
    inMag = 4'(x); inSign = xs; wtMag = 4'(w); wtSign = ws; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    chk("R2 cleared mag", prodMag, 0);
    chk("R2 cleared sign", prodSign, 0);
    for (int i = 0; i < L - 1; i++) begin
      if (scramble) begin
        inMag = 4'(15 - x); wtMag = 4'(15 - w); inSign = ~xs; wtSign = ws;
      end
      @(negedge clk);
      if (prodValid) chk("R3 early valid", 1, 0);
    end
    @(negedge clk);
    chk("R3 valid on slot 15", prodValid, 1);
    chk(scramble ? "R7 mag after mid-frame change" : "R4 magnitude", prodMag, expMag);
    chk((x == 0 || w == 0) ? "R6 zero operand sign" : "R5 sign", prodSign, expSign);
    if (x == 0 || w == 0) chk("R6 zero operand mag", prodMag, 0);
    @(negedge clk);
    chk("R3 valid one cycle", prodValid, 0);
    chk("R9 held mag", prodMag, expMag);
    chk("R9 held sign", prodSign, expSign);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mag", prodMag, 0);
    chk("R1 reset sign", prodSign, 0);
    chk("R1 reset valid", prodValid, 0);
    rstN = 1'b1;
    @(negedge clk);

    runFrame(8, 0, 9, 0, 0);   // rounding example: 5
    runFrame(15, 1, 15, 0, 0); // full scale negative
    runFrame(1, 0, 7, 1, 0);   // rounds to zero, must be positive
    runFrame(1, 1, 8, 0, 0);   // rounds up to 1
    runFrame(0, 1, 15, 0, 0);  // R6
    runFrame(12, 0, 0, 1, 0);  // R6
    runFrame(8, 0, 9, 1, 1);   // R7
    runFrame(3, 1, 14, 1, 1);  // R7

    for (int x = 0; x < 16; x++)
      for (int w = 0; w < 16; w++)
        runFrame(x, bit'(x & 1), w, bit'((w >> 1) & 1), 0);

    // R8: restart in the middle of a frame
    inMag = 4'd15; wtMag = 4'd15; inSign = 0; wtSign = 0; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    repeat (4) @(negedge clk);
    runFrame(3, 0, 5, 1, 0);   // lvl(3,5)=1, negative

    // result still held with no frames running
    repeat (20) @(negedge clk);
    chk("R9 idle hold mag", prodMag, 1);
    chk("R3 idle no valid", prodValid, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog R3 actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule